// File: doc/BRIEF.md
# Reconfigurable Post-Scale Clock Divider

The block takes a fast source clock and produces a slower clock whose period is the sum of a programmable high-time count and a programmable low-time count. Both counts are measured in source-clock cycles. The duty cycle is therefore set directly by the split between the two counts. A bypass setting passes the source clock straight through, which gives divide-by-1. A half-cycle setting moves the falling output edge to the falling edge of the source clock. The high time then shortens by half a source cycle and the low time grows by half a cycle, so an odd total such as 2+1 produces a 50/50 output.

New settings are written into shadow registers with a single write strobe. The running counter copies the shadow settings only when a new output period begins. The period in progress therefore always completes with the settings it started with, and no runt pulse appears. Phase adjustment of the output is not part of this block. Reprogramming the division leaves any phase offset applied elsewhere untouched.

Top module: `postscale_div`

## Requirements
- R1: With bypass 0 and half-cycle 0, the output is high for H source cycles and low for L source cycles, where H and L are the active high and low counts. Rising and falling output edges both line up with rising source edges.
- R2: A count field of 0 stands for 256. For example, H=0 and L=1 gives 256 cycles high and 1 cycle low.
- R3: With half-cycle 1 (and bypass 0), the output falls on the falling source edge inside the last high cycle. The high time becomes H-0.5 cycles and the low time becomes L+0.5 cycles. H=2, L=1 gives 1.5/1.5.
- R4: With bypass 1, the output equals the source clock, regardless of the counts and the half-cycle bit.
- R5: A write (cfg_we=1 on a rising source edge) updates only the shadow settings. The active settings are replaced only at the first rising source edge of the next output period, so the period in progress finishes unchanged.
- R6: While rst is sampled 1, the output is 0 and both shadow and active settings return to H=1, L=1, bypass 0, half-cycle 0. Writes during reset are ignored. The first rising source edge after release starts a high phase.
- R7: While the counter runs, the cycle count stays below the active count of its current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast source clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe that loads the shadow settings |
| cfg_high | input | CNT_W | High-time count in source cycles (0 means 256) |
| cfg_low | input | CNT_W | Low-time count in source cycles (0 means 256) |
| cfg_bypass | input | 1 | 1 passes the source clock through undivided |
| cfg_odd | input | 1 | 1 moves the falling edge half a source cycle earlier |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest situation to reach from the ports is a write that arrives in the middle of a long output period. To show that it does not disturb that period, the stimulus must first detect a rising output edge. The new settings are then written a few cycles later, inside the high phase of a 10+10 period. The old widths must hold for that period and the new ones must appear in the next. Widths are measured by sampling the output once in each source half-cycle. This makes the half-cycle shift visible as an odd count of samples.

// File: rtl/postscale_div.sv
module postscale_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_bypass,
  input  logic             cfg_odd,
  output logic             clk_out
);
  localparam int EW = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] sh_high, sh_low, act_high, act_low, cnt;
  logic             sh_byp, sh_odd, act_byp, act_odd;
  logic             hi_ph, fresh, neg_q;

  // a zero field reads as 2**CNT_W
  wire [EW-1:0] hi_eff  = {act_high == '0, act_high};
  wire [EW-1:0] lo_eff  = {act_low == '0, act_low};
  wire          last_hi = hi_ph && ({1'b0, cnt} == hi_eff - EW'(1));
  wire          last_lo = !hi_ph && (fresh || ({1'b0, cnt} == lo_eff - EW'(1)));

  always_ff @(posedge clk_in) begin
    if (rst) begin
      sh_high  <= ONE;
      sh_low   <= ONE;
      sh_byp   <= 1'b0;
      sh_odd   <= 1'b0;
      act_high <= ONE;
      act_low  <= ONE;
      act_byp  <= 1'b0;
      act_odd  <= 1'b0;
      hi_ph    <= 1'b0;
      fresh    <= 1'b1;
      cnt      <= '0;
    end else begin
      if (cfg_we) begin
        sh_high <= cfg_high;
        sh_low  <= cfg_low;
        sh_byp  <= cfg_bypass;
        sh_odd  <= cfg_odd;
      end
      if (last_lo) begin
        act_high <= sh_high;
        act_low  <= sh_low;
        act_byp  <= sh_byp;
        act_odd  <= sh_odd;
        hi_ph    <= 1'b1;
        fresh    <= 1'b0;
        cnt      <= '0;
      end else if (last_hi) begin
        hi_ph <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // mid-cycle sample of the final high cycle trims half a period when enabled
  always_ff @(negedge clk_in) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= last_hi;
  end

  wire div_out = hi_ph & ~(act_odd & neg_q);
  assign clk_out = act_byp ? clk_in : div_out;

endmodule

// File: rtl/postscale_div_chk.sv
module postscale_div_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_in,
  input logic             rst,
  input logic             clk_out,
  input logic             hi_ph,
  input logic             fresh,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_high,
  input logic [CNT_W-1:0] act_low,
  input logic             act_byp
);
  AST_RESET_LOW: assert property (@(posedge clk_in) rst |=> !clk_out); // R6
  AST_RESTART_HIGH: assert property (@(posedge clk_in) disable iff (rst) $fell(rst) |=> clk_out); // R6
  AST_SHADOW_SWAP: assert property (@(posedge clk_in) disable iff (rst) !$stable({act_high, act_low, act_byp}) |-> $rose(hi_ph)); // R5
  AST_BYPASS_FOLLOW: assert property (@(negedge clk_in) disable iff (rst) act_byp |-> clk_out); // R4
  AST_HI_RANGE: assert property (@(posedge clk_in) disable iff (rst) hi_ph |-> ({1'b0, cnt} < {act_high == '0, act_high})); // R7
  AST_LO_RANGE: assert property (@(posedge clk_in) disable iff (rst) (!hi_ph && !fresh) |-> ({1'b0, cnt} < {act_low == '0, act_low})); // R7
endmodule

bind postscale_div postscale_div_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_postscale_div.sv
module sim_postscale_div;
  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0, cfg_bypass = 1'b0, cfg_odd = 1'b0;
  logic [7:0] cfg_high = 8'd1, cfg_low = 8'd1;
  logic clk_out;
  int checks = 0, fails = 0, prev_per = 2;
  int hi_w, lo_w;

  always #10 clk = ~clk;

  postscale_div #(.CNT_W(8)) u0 (.clk_in(clk), .rst(rst), .cfg_we(cfg_we), .cfg_high(cfg_high),
    .cfg_low(cfg_low), .cfg_bypass(cfg_bypass), .cfg_odd(cfg_odd), .clk_out(clk_out));

  // {bypass, odd, high, low}
  localparam logic [17:0] VEC [12] = '{
    {2'b00, 8'd2, 8'd1}, {2'b01, 8'd2, 8'd1}, {2'b00, 8'd5, 8'd5}, {2'b00, 8'd4, 8'd6},
    {2'b00, 8'd1, 8'd1}, {2'b01, 8'd1, 8'd1}, {2'b01, 8'd3, 8'd4}, {2'b00, 8'd0, 8'd1},
    {2'b01, 8'd7, 8'd0}, {2'b10, 8'd3, 8'd2}, {2'b11, 8'd3, 8'd2}, {2'b00, 8'd255, 8'd3}};

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 256 : int'(v);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] h, input logic [7:0] l, input logic b, input logic o);
    @(negedge clk);
    cfg_high = h; cfg_low = l; cfg_bypass = b; cfg_odd = o; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns at the first half-cycle sample that shows the output high after a low one
  task automatic wait_rise();
    logic prev, cur;
    @(posedge clk); #5;
    prev = clk_out;
    for (int i = 0; i < 4000; i++) begin
      #10; cur = clk_out;
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic count_runs(output int h, output int l);
    h = 1; l = 0;
    for (int i = 0; i < 2000; i++) begin
      #10;
      if (clk_out) h++; else break;
    end
    l = 1;
    for (int i = 0; i < 2000; i++) begin
      #10;
      if (!clk_out) l++; else break;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R6: output low and held during reset
    repeat (3) @(posedge clk);
    #5 check("R6", "out in reset hi half", int'(clk_out), 0);
    #10 check("R6", "out in reset lo half", int'(clk_out), 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #5 check("R6", "first half after release", int'(clk_out), 1);
    wait_rise(); count_runs(hi_w, lo_w);
    check("R6", "default high width", hi_w, 2);
    check("R6", "default low width", lo_w, 2);

    foreach (VEC[i]) begin
      logic b, o; logic [7:0] h, l; int eh, el; string tag;
      {b, o, h, l} = VEC[i];
      write_cfg(h, l, b, o);
      repeat (prev_per + 2 * (eff(h) + eff(l)) + 4) @(posedge clk);
      prev_per = eff(h) + eff(l);
      if (b) begin eh = 1; el = 1; tag = "R4"; end
      else if (o) begin eh = 2 * eff(h) - 1; el = 2 * eff(l) + 1; tag = "R3"; end
      else begin eh = 2 * eff(h); el = 2 * eff(l); tag = (h == 0 || l == 0) ? "R2" : "R1"; end
      wait_rise(); count_runs(hi_w, lo_w);
      check(tag, $sformatf("vec %0d high", i), hi_w, eh);
      check(tag, $sformatf("vec %0d low", i), lo_w, el);
    end

    // R5: write inside a running high phase leaves that period intact
    write_cfg(8'd10, 8'd10, 1'b0, 1'b0);
    repeat (prev_per + 50) @(posedge clk);
    wait_rise();
    fork
      count_runs(hi_w, lo_w);
      begin #60; write_cfg(8'd2, 8'd2, 1'b0, 1'b0); end
    join
    check("R5", "old high kept", hi_w, 20);
    check("R5", "old low kept", lo_w, 20);
    count_runs(hi_w, lo_w);
    check("R5", "new high next period", hi_w, 4);
    check("R5", "new low next period", lo_w, 4);

    // R6: reset restores defaults, write during reset ignored
    write_cfg(8'd7, 8'd3, 1'b0, 1'b1);
    @(negedge clk) rst = 1'b1;
    write_cfg(8'd9, 8'd9, 1'b1, 1'b0);
    @(negedge clk) rst = 1'b0;
    wait_rise(); count_runs(hi_w, lo_w);
    check("R6", "high after reset", hi_w, 2);
    check("R6", "low after reset", lo_w, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule